// File: doc/BRIEF.md
# Iterated MixColumns Power-Stress Loop

This block keeps a deep, XOR-heavy combinational network busy on one 32-bit data word for a fixed run of clock cycles. Two 32-bit registers swap contents every cycle. The loop input therefore alternates between all-zero and the running value, and the switching activity of the network is as high as possible. The network is a cascade of six AES-style column transforms. A registered depth bit selects whether three or all six stages carry data. When only three carry data, the last three see a forced zero input.

A `start` pulse in the idle or finished state loads the input word and clears the partner register. The block then waits a fixed number of idle cycles, iterates for a fixed number of cycles, and raises a registered `done`. While `done` is low, `y` reads zero. Once `done` is high, `y` shows the first register. With the default run of 16 iterations, the column transform is applied a multiple of four times, and its fourth power is the identity. The word therefore comes back unchanged for either depth.

The control state machine has four states:
- ST_IDLE, left on `start` for ST_GAP, or for ST_RUN when the gap is zero.
- ST_GAP, left for ST_RUN when the idle count expires.
- ST_RUN, left for ST_DONE after the last iteration.
- ST_DONE, left on `start` the same way as ST_IDLE.

Top module: `mcl_top`

## Requirements
- R1: A `start` accepted in ST_IDLE or ST_DONE loads `x` into the first register, clears the second register, latches `deep`, and clears `done` at the same edge.
- R2: On each iteration edge, the second register takes the old first register, and the first register takes the chain output computed from the old second register.
- R3: Each stage maps a column of bytes b0..b3 (b0 = bits 31:24, b3 = bits 7:0) to out_i = 2·b_i ⊕ 3·b_(i+1) ⊕ b_(i+2) ⊕ b_(i+3), with indices taken modulo 4. Products are formed in GF(2^8) reduced by 0x11B.
- R4: A latched depth bit of 0 gives a three-stage chain, and the last three stages are fed zero. A latched depth bit of 1 gives all six stages. A change on the `deep` pin after `start` has no effect on the run.
- R5: Exactly GAP_CYCLES idle edges, during which both registers hold, separate the load edge from the first iteration edge.
- R6: `done` rises at the edge that completes iteration ITERS, counted as GAP_CYCLES+ITERS edges after the load edge. It then stays high, with `y` stable, until the next accepted `start`.
- R7: With ITERS = 16, `y` equals the loaded `x` for both depths.
- R8: A `start` pulse during ST_GAP or ST_RUN is ignored.
- R9: With `x` = 0, every register stays zero and `y` reads zero.
- R10: After reset, the machine is in ST_IDLE, both registers are zero, `done` is 0 and `y` is 0.
- R11: While `done` is low, `y` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load and begin a run (ST_IDLE or ST_DONE only) |
| deep | input | 1 | Depth request: 0 = three stages, 1 = six stages |
| x | input | 32 | Data word loaded on start |
| done | output | 1 | Registered run-complete flag |
| y | output | 32 | First register when done, otherwise zero |

## Verification
The bench runs a second, shallower instance with six iterations. At that count the result is one transform at depth three and two transforms at depth six, so a wrong byte order, a wrong reduction constant or a leaked shallow/deep selection shows up as a wrong word. The full instance would hide such errors behind the identity. The sweep pulses `start` and flips `deep` in the middle of a run. A machine that restarts when busy, or that reads the live pin, returns the disturbed word. The bench measures the edge on which `done` rises, which exposes an off-by-one in the gap or iteration counter. An all-zero input must stay zero throughout.

// File: rtl/mcl_pkg.sv
package mcl_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = WORD_W / BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_RUN,
        ST_DONE
    } mcl_state_e;

    // Doubling in GF(2^8) with reduction polynomial 0x11B
    function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] b);
        gf_dbl = {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? 8'h1B : 8'h00);
    endfunction

endpackage

// File: rtl/mcl_stage.sv
module mcl_stage
    import mcl_pkg::*;
(
    input  logic [WORD_W-1:0] col_in,
    output logic [WORD_W-1:0] col_out
);

    logic [BYTE_W-1:0] b [N_BYTES];

    genvar gi;
    generate
        for (gi = 0; gi < N_BYTES; gi++) begin : g_split
            assign b[gi] = col_in[WORD_W-1-gi*BYTE_W -: BYTE_W];
        end
        for (gi = 0; gi < N_BYTES; gi++) begin : g_row
            localparam int I1 = (gi + 1) % N_BYTES;
            localparam int I2 = (gi + 2) % N_BYTES;
            localparam int I3 = (gi + 3) % N_BYTES;
            assign col_out[WORD_W-1-gi*BYTE_W -: BYTE_W] =
                gf_dbl(b[gi]) ^ gf_dbl(b[I1]) ^ b[I1] ^ b[I2] ^ b[I3];
        end
    endgenerate

endmodule

// File: rtl/mcl_chain.sv
module mcl_chain
    import mcl_pkg::*;
#(
    parameter int STAGES  = 6,
    parameter int SHALLOW = 3
) (
    input  logic              deep_q,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);

    logic [WORD_W-1:0] s_in  [STAGES];
    logic [WORD_W-1:0] s_out [STAGES];

    genvar gs;
    generate
        for (gs = 0; gs < STAGES; gs++) begin : g_stage
            if (gs == 0) begin : g_first
                assign s_in[gs] = din;
            end else if (gs == SHALLOW) begin : g_gate
                // upper stages see zero whenever the short chain is chosen
                assign s_in[gs] = deep_q ? s_out[gs-1] : '0;
            end else begin : g_link
                assign s_in[gs] = s_out[gs-1];
            end
            mcl_stage u_stage (
                .col_in  (s_in[gs]),
                .col_out (s_out[gs])
            );
        end
    endgenerate

    assign dout = deep_q ? s_out[STAGES-1] : s_out[SHALLOW-1];

endmodule

// File: rtl/mcl_ctrl.sv
module mcl_ctrl
    import mcl_pkg::*;
#(
    parameter int GAP_CYCLES = 3,
    parameter int ITERS      = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output mcl_state_e state,
    output logic       load_en,
    output logic       iter_en,
    output logic       done_q
);

    localparam int CNT_MAX = (GAP_CYCLES > ITERS) ? GAP_CYCLES : ITERS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] GAP_LAST =
        (GAP_CYCLES > 0) ? CNT_W'(GAP_CYCLES - 1) : '0;
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(ITERS - 1);

    mcl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= (state_d == ST_DONE);
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d = (GAP_CYCLES > 0) ? ST_GAP : ST_RUN;
                    cnt_d   = '0;
                end
            end
            ST_GAP: begin
                if (cnt_q == GAP_LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (cnt_q == RUN_LAST) begin
                    state_d = ST_DONE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        load_en = 1'b0;
        iter_en = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: load_en = start;
            ST_RUN:           iter_en = 1'b1;
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/mcl_top.sv
module mcl_top
    import mcl_pkg::*;
#(
    parameter int GAP_CYCLES = 3,
    parameter int ITERS      = 16,
    parameter int STAGES     = 6,
    parameter int SHALLOW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              deep,
    input  logic [WORD_W-1:0] x,
    output logic              done,
    output logic [WORD_W-1:0] y
);

    mcl_state_e        state;
    logic              load_en, iter_en, deep_q;
    logic [WORD_W-1:0] r0_q, r1_q, chain_out;

    mcl_ctrl #(
        .GAP_CYCLES (GAP_CYCLES),
        .ITERS      (ITERS)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .state   (state),
        .load_en (load_en),
        .iter_en (iter_en),
        .done_q  (done)
    );

    mcl_chain #(
        .STAGES  (STAGES),
        .SHALLOW (SHALLOW)
    ) u_chain (
        .deep_q (deep_q),
        .din    (r1_q),
        .dout   (chain_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r0_q   <= '0;
            r1_q   <= '0;
            deep_q <= 1'b0;
        end else if (load_en) begin
            r0_q   <= x;
            r1_q   <= '0;
            deep_q <= deep;
        end else if (iter_en) begin
            r0_q <= chain_out;
            r1_q <= r0_q;
        end
    end

    assign y = done ? r0_q : '0;

endmodule

// File: rtl/mcl_checker.sv
module mcl_checker
    import mcl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input mcl_state_e        state,
    input logic              start,
    input logic [WORD_W-1:0] x,
    input logic [WORD_W-1:0] r0,
    input logic [WORD_W-1:0] r1,
    input logic              setting,
    input logic              done,
    input logic [WORD_W-1:0] y
);

    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE || state == ST_DONE) && start)
        |=> (r1 == '0 && r0 == $past(x) && !done));

    assert_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (r1 == $past(r0)));

    assert_depth_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP || state == ST_RUN) |=> $stable(setting));

    assert_gap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |=> ($stable(r0) && $stable(r1)));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(y)));

    assert_busy_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && start) |=> (state != ST_IDLE && !done));

endmodule

bind mcl_top mcl_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .start   (start),
    .x       (x),
    .r0      (r0_q),
    .r1      (r1_q),
    .setting (deep_q),
    .done    (done),
    .y       (y)
);

// File: tb/mcl_top_bench.sv
module mcl_top_bench;

    localparam int G_L = 3;
    localparam int I_L = 16;
    localparam int G_S = 0;
    localparam int I_S = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        deep = 1'b0;
    logic [31:0] x_in = '0;
    logic        done_l, done_s;
    logic [31:0] y_l, y_s;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    mcl_top #(.GAP_CYCLES(G_L), .ITERS(I_L)) u_mcl_top (
        .clk(clk), .rst_n(rst_n), .start(start), .deep(deep), .x(x_in),
        .done(done_l), .y(y_l)
    );

    mcl_top #(.GAP_CYCLES(G_S), .ITERS(I_S)) u_short (
        .clk(clk), .rst_n(rst_n), .start(start), .deep(deep), .x(x_in),
        .done(done_s), .y(y_s)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual %0d cycles expected < 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] dbl(input logic [7:0] v);
        logic [8:0] t;
        t = {v, 1'b0};
        if (t[8]) t = t ^ 9'h11B;
        return t[7:0];
    endfunction

    function automatic logic [31:0] col(input logic [31:0] w);
        logic [7:0] b [4];
        logic [31:0] r;
        for (int i = 0; i < 4; i++) b[i] = w[31-8*i -: 8];
        r = '0;
        for (int i = 0; i < 4; i++)
            r[31-8*i -: 8] = dbl(b[i]) ^ dbl(b[(i+1)%4]) ^ b[(i+1)%4]
                           ^ b[(i+2)%4] ^ b[(i+3)%4];
        return r;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] v, input logic dp, input int n);
        logic [31:0] a, b, c;
        a = v; b = '0;
        for (int k = 0; k < n; k++) begin
            c = b;
            for (int s = 0; s < (dp ? 6 : 3); s++) c = col(c);
            b = a;
            a = c;
        end
        return a;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [31:0] v, input logic dp, input bit disturb);
        int kl, ks;
        logic [31:0] mid_y;
        @(negedge clk);
        start = 1'b1; x_in = v; deep = dp;
        @(negedge clk);
        start = 1'b0;
        kl = 0; ks = 0; mid_y = 32'hDEAD_BEEF;
        for (int k = 1; k <= 40; k++) begin
            if (k > 1) @(negedge clk);
            if (k == 1) begin
                check("R1 done cleared by start (long)", {31'd0, done_l}, 32'd0);
                check("R11 y zero before done", y_l, 32'd0);
            end
            if (disturb && k == 2) begin
                start = 1'b1; x_in = ~v; deep = ~dp;
            end
            if (disturb && k == 3) start = 1'b0;
            if (ks == 0 && done_s) begin ks = k; mid_y = y_l; end
            if (kl == 0 && done_l) kl = k;
        end
        check("R5 R6 done edge long", kl, G_L + I_L + 1);
        check("R6 done edge short", ks, G_S + I_S + 1);
        check("R11 long y zero while running", mid_y, 32'd0);
        check("R7 long result", y_l, v);
        check(disturb ? "R4 R8 long result after disturbance" : "R2 long model", y_l, model(v, dp, I_L));
        check(disturb ? "R4 R8 short result after disturbance" : "R3 R4 short model", y_s, model(v, dp, I_S));
        check("R3 short one/two column transforms", y_s, dp ? col(col(v)) : col(v));
        if (v == 32'd0) check("R9 zero input", y_l | y_s, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset done", {30'd0, done_l, done_s}, 32'd0);
        check("R10 reset y", y_l | y_s, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", y_l | {31'd0, done_l}, 32'd0);

        run_case(32'd0, 1'b0, 1'b0);
        run_case(32'd0, 1'b1, 1'b0);
        for (int b = 0; b < 32; b++) begin
            run_case(32'd1 << b, 1'b0, 1'b0);
            run_case(32'd1 << b, 1'b1, 1'b0);
        end
        run_case(32'hDB13_5345, 1'b0, 1'b0);
        run_case(32'hF20A_225C, 1'b1, 1'b0);
        run_case(32'hFFFF_FFFF, 1'b1, 1'b0);
        run_case(32'h8080_8080, 1'b0, 1'b0);
        run_case(32'h1234_5678, 1'b0, 1'b1);
        run_case(32'hC6C6_C6C6, 1'b1, 1'b1);

        repeat (5) @(negedge clk);
        check("R6 done held without start", {31'd0, done_l}, 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule